// File: doc/BRIEF.md
# Protected flash command sequence decoder

This block sits beside the byte-write path of a parallel flash-style memory. It watches each accepted write, an address and a data byte, and recognises the multi-write unlock commands. All of them share one two-write prefix. The third data byte then picks one of four actions. It can grant a single sector-write permission. It can enter or leave the product-identification mode. It can continue into a longer path that ends in a lockout-arm request for one of the two boot blocks. Writes that do not fit any command store nothing, and they are flagged so that the busy timer outside can still be started.

While identification mode is on, the block supplies the read path with the maker and device code bytes and with the lockout status of each boot block. It raises a hit flag so that the read multiplexer outside takes these bytes in place of array data. Byte loading, programming timers and the memory array are outside this block.

The write port is a valid/ready stream. `wr_ready` is always high, so the block never applies back-pressure. A write counts in every cycle where `wr_valid` is high. All mode flags and pulses are registered and change in the cycle after the write that causes them. The identification read path is combinational from `rd_addr`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The writes AA to 5555, then 55 to 2AAA, then A0 to 5555 set `sector_wr_en` in the cycle after the third write.
- R2: `sector_wr_en` stays high until `prog_done` is seen, and it is low in the following cycle. While it is high, writes go to the byte loader: they cause no `stray_wr` and no mode change.
- R3: The prefix followed by 90 to 5555 sets `id_mode` in the cycle after the third write.
- R4: The prefix followed by F0 to 5555 clears `id_mode` in the cycle after the third write.
- R5: While `id_mode` is high, a read whose address bits above bit 0 are all zero gives `id_rd_hit`=1 and `id_rd_data`=1F for bit 0 = 0, or C4 for bit 0 = 1. While `id_mode` is low, `id_rd_hit` is 0.
- R6: While `id_mode` is high, a read of address 2 returns FE when `lock_status[0]` (lower block) is 0 and FF when it is 1. A read of the address that is all ones except a low nibble of 2 (7FFF2 at 19 bits) reports `lock_status[1]` (upper block) in the same way. Any other address gives `id_rd_hit`=0.
- R7: The writes AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 40/5555 arm the lockout path. A seventh write of 00 to address 0 then pulses `lock_arm_lo` for one cycle. A seventh write of FF to the low-15-bits-all-ones address pulses `lock_arm_hi` for one cycle instead.
- R8: Only address bits 14..0 are compared for command writes, so bits above 14 are ignored. All 8 data bits are compared.
- R9: A write that breaks a partly matched sequence returns the matcher to idle. If that same write is AA to 5555, it counts as the first write of a new sequence.
- R10: `stray_wr` pulses for one cycle, in the cycle after any decoded write that neither advances nor starts a command sequence.
- R11: Reset (active-low `rst_n`) clears `id_mode`, `sector_wr_en`, every pulse output and the matcher state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also stands for power-down |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_ready | output | 1 | Always 1; the block never applies back-pressure |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| prog_done | input | 1 | The programming cycle has finished; protection turns back on |
| rd_addr | input | AW | Read address |
| lock_status | input | 2 | Boot-block lockout state: bit 0 lower, bit 1 upper; 1 = locked |
| id_rd_hit | output | 1 | The read path must use `id_rd_data` |
| id_rd_data | output | 8 | Identification or lockout status byte |
| sector_wr_en | output | 1 | One sector-program operation is permitted |
| id_mode | output | 1 | Product-identification mode is on |
| lock_arm_lo | output | 1 | One-cycle request to lock the lower boot block |
| lock_arm_hi | output | 1 | One-cycle request to lock the upper boot block |
| stray_wr | output | 1 | One-cycle pulse for a write that is not part of a command |

## Verification
A wrong matcher state shows up at the latest on the write that should have finished a sequence. That write then gives a missing or wrong mode change, or a `stray_wr` pulse where none belongs, exactly one cycle after it. A wrong step can also show up earlier: a correct command write that is flagged stray points at the wrong step. A stuck or wrongly set `id_mode` is seen at once on the combinational identification read path, because `id_rd_hit` and the code bytes follow `rd_addr` in the same cycle.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
  localparam int CMD_AW = 15;   // address bits compared for command writes
  localparam int NPAT   = 9;    // number of address/data patterns

  // Pattern indices
  localparam int P_AA   = 0;    // AA @ 5555
  localparam int P_55   = 1;    // 55 @ 2AAA
  localparam int P_WEN  = 2;    // A0 @ 5555
  localparam int P_IDIN = 3;    // 90 @ 5555
  localparam int P_IDEX = 4;    // F0 @ 5555
  localparam int P_LK80 = 5;    // 80 @ 5555
  localparam int P_LK40 = 6;    // 40 @ 5555
  localparam int P_ARML = 7;    // 00 @ 0000
  localparam int P_ARMH = 8;    // FF @ 7FFF

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_L3, ST_L4, ST_L5, ST_L6
  } seq_state_t;

  function automatic logic [CMD_AW-1:0] pat_addr(input int i);
    case (i)
      P_55:    pat_addr = 15'h2AAA;
      P_ARML:  pat_addr = 15'h0000;
      P_ARMH:  pat_addr = 15'h7FFF;
      default: pat_addr = 15'h5555;
    endcase
  endfunction

  function automatic logic [7:0] pat_data(input int i);
    case (i)
      P_AA:    pat_data = 8'hAA;
      P_55:    pat_data = 8'h55;
      P_WEN:   pat_data = 8'hA0;
      P_IDIN:  pat_data = 8'h90;
      P_IDEX:  pat_data = 8'hF0;
      P_LK80:  pat_data = 8'h80;
      P_LK40:  pat_data = 8'h40;
      P_ARML:  pat_data = 8'h00;
      default: pat_data = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/flash_cmd_match.sv
`timescale 1ns/1ps
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      data,
  output logic [NPAT-1:0] hit
);
  // Upper address bits take no part in the comparison (R8)
  logic [CMD_AW-1:0] low_addr;
  assign low_addr = addr[CMD_AW-1:0];

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    assign hit[g] = (low_addr == pat_addr(g)) && (data == pat_data(g));
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [NPAT-1:0] hit,
  input  logic            prog_done,
  output logic            sector_wr_en,
  output logic            id_mode,
  output logic            lock_arm_lo,
  output logic            lock_arm_hi,
  output logic            stray_wr
);
  seq_state_t state, state_nxt;
  logic dec, adv, set_wen, set_id, clr_id, arm_lo, arm_hi;

  // Writes are byte loads while a sector write is open (R2)
  assign dec = wr_valid && !sector_wr_en;

  always_comb begin
    state_nxt = state;
    adv       = 1'b0;
    set_wen   = 1'b0;
    set_id    = 1'b0;
    clr_id    = 1'b0;
    arm_lo    = 1'b0;
    arm_hi    = 1'b0;
    if (dec) begin
      case (state)
        ST_IDLE: if (hit[P_AA]) begin adv = 1'b1; state_nxt = ST_U1; end
        ST_U1:   if (hit[P_55]) begin adv = 1'b1; state_nxt = ST_U2; end
        ST_U2: begin
          if (hit[P_WEN])       begin adv = 1'b1; set_wen = 1'b1; state_nxt = ST_IDLE; end
          else if (hit[P_IDIN]) begin adv = 1'b1; set_id  = 1'b1; state_nxt = ST_IDLE; end
          else if (hit[P_IDEX]) begin adv = 1'b1; clr_id  = 1'b1; state_nxt = ST_IDLE; end
          else if (hit[P_LK80]) begin adv = 1'b1; state_nxt = ST_L3; end
        end
        ST_L3: if (hit[P_AA])   begin adv = 1'b1; state_nxt = ST_L4; end
        ST_L4: if (hit[P_55])   begin adv = 1'b1; state_nxt = ST_L5; end
        ST_L5: if (hit[P_LK40]) begin adv = 1'b1; state_nxt = ST_L6; end
        ST_L6: begin
          if (hit[P_ARML])      begin adv = 1'b1; arm_lo = 1'b1; state_nxt = ST_IDLE; end
          else if (hit[P_ARMH]) begin adv = 1'b1; arm_hi = 1'b1; state_nxt = ST_IDLE; end
        end
        default: state_nxt = ST_IDLE;
      endcase
      // Broken sequence: back to idle, but the same write may start anew (R9)
      if (!adv) state_nxt = hit[P_AA] ? ST_U1 : ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      sector_wr_en <= 1'b0;
      id_mode      <= 1'b0;
      lock_arm_lo  <= 1'b0;
      lock_arm_hi  <= 1'b0;
      stray_wr     <= 1'b0;
    end else begin
      state       <= state_nxt;
      lock_arm_lo <= arm_lo;
      lock_arm_hi <= arm_hi;
      stray_wr    <= dec && !adv && !hit[P_AA];
      if (set_wen)        sector_wr_en <= 1'b1;
      else if (prog_done) sector_wr_en <= 1'b0;
      if (set_id)         id_mode <= 1'b1;
      else if (clr_id)    id_mode <= 1'b0;
    end
  end

  // R2: a finished program cycle closes the write permission
  p_wen_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sector_wr_en && prog_done |=> !sector_wr_en);
  // R2: byte loads during an open sector write are never stray
  p_load_not_stray_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sector_wr_en && wr_valid |=> !stray_wr);
  // R3: identification mode only turns on after a write
  p_id_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_valid));
  // R4: identification mode only turns off after a write
  p_id_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(wr_valid));
  // R7: at most one boot block armed, and only as a single-cycle pulse
  p_arm_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock_arm_lo, lock_arm_hi}));
  p_arm_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_arm_lo || lock_arm_hi) |=> !(lock_arm_lo || lock_arm_hi));
  // R10: a stray flag always follows a write
  p_stray_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |-> $past(wr_valid));
endmodule

// File: rtl/flash_id_read.sv
`timescale 1ns/1ps
module flash_id_read #(
  parameter int AW = 19
) (
  input  logic          id_mode,
  input  logic [AW-1:0] rd_addr,
  input  logic [1:0]    lock_status,
  output logic          id_rd_hit,
  output logic [7:0]    id_rd_data
);
  localparam logic [7:0]    MAKER_CODE = 8'h1F;
  localparam logic [7:0]    DEV_CODE   = 8'hC4;
  localparam logic [AW-1:0] LO_STAT_A  = AW'(2);
  localparam logic [AW-1:0] HI_STAT_A  = {{(AW-4){1'b1}}, 4'h2};

  always_comb begin
    id_rd_hit  = 1'b0;
    id_rd_data = 8'h00;
    if (id_mode) begin
      if (rd_addr[AW-1:1] == '0) begin
        id_rd_hit  = 1'b1;
        id_rd_data = rd_addr[0] ? DEV_CODE : MAKER_CODE;
      end else if (rd_addr == LO_STAT_A) begin
        id_rd_hit  = 1'b1;
        id_rd_data = {7'b1111111, lock_status[0]};
      end else if (rd_addr == HI_STAT_A) begin
        id_rd_hit  = 1'b1;
        id_rd_data = {7'b1111111, lock_status[1]};
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          prog_done,
  input  logic [AW-1:0] rd_addr,
  input  logic [1:0]    lock_status,
  output logic          id_rd_hit,
  output logic [7:0]    id_rd_data,
  output logic          sector_wr_en,
  output logic          id_mode,
  output logic          lock_arm_lo,
  output logic          lock_arm_hi,
  output logic          stray_wr
);
  logic [NPAT-1:0] hit;

  assign wr_ready = 1'b1;

  flash_cmd_match #(.AW(AW)) u_match (
    .addr (wr_addr),
    .data (wr_data),
    .hit  (hit)
  );

  flash_cmd_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .hit          (hit),
    .prog_done    (prog_done),
    .sector_wr_en (sector_wr_en),
    .id_mode      (id_mode),
    .lock_arm_lo  (lock_arm_lo),
    .lock_arm_hi  (lock_arm_hi),
    .stray_wr     (stray_wr)
  );

  flash_id_read #(.AW(AW)) u_idrd (
    .id_mode     (id_mode),
    .rd_addr     (rd_addr),
    .lock_status (lock_status),
    .id_rd_hit   (id_rd_hit),
    .id_rd_data  (id_rd_data)
  );

  // R5: identification bytes reach the read path only in identification mode
  p_id_read_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd_hit |-> id_mode);
endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
  localparam int AW = 19;
  localparam int NV = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          prog_done = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    lock_status = 2'b00;
  logic          id_rd_hit;
  logic [7:0]    id_rd_data;
  logic          sector_wr_en, id_mode, lock_arm_lo, lock_arm_hi, stray_wr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
    .rd_addr(rd_addr), .lock_status(lock_status), .id_rd_hit(id_rd_hit),
    .id_rd_data(id_rd_data), .sector_wr_en(sector_wr_en), .id_mode(id_mode),
    .lock_arm_lo(lock_arm_lo), .lock_arm_hi(lock_arm_hi), .stray_wr(stray_wr)
  );

  // Stimulus table: address, data, expected {wen, id, arm_lo, arm_hi, stray}
  localparam logic [AW-1:0] VA [NV] = '{
    19'h05555, 19'h02AAA, 19'h05555, 19'h01234,
    19'h05555, 19'h02AAA, 19'h05555,
    19'h7D555, 19'h02AAA, 19'h05555, 19'h05555, 19'h02AAA, 19'h05555, 19'h00000,
    19'h05555, 19'h02AAA, 19'h05555, 19'h05555, 19'h02AAA, 19'h05555, 19'h7FFFF,
    19'h05555, 19'h02AAA, 19'h02AAA,
    19'h05555, 19'h05555, 19'h02AAA, 19'h05555
  };
  localparam logic [7:0] VD [NV] = '{
    8'hAA, 8'h55, 8'h90, 8'h12,
    8'hAA, 8'h55, 8'hF0,
    8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h40, 8'h00,
    8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h40, 8'hFF,
    8'hAA, 8'hAB, 8'h55,
    8'hAA, 8'hAA, 8'h55, 8'hA0
  };
  localparam logic [4:0] VE [NV] = '{
    5'b00000, 5'b00000, 5'b01000, 5'b01001,
    5'b01000, 5'b01000, 5'b00000,
    5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00100,
    5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00010,
    5'b00000, 5'b00001, 5'b00001,
    5'b00000, 5'b00000, 5'b00000, 5'b10000
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] flags();
    return {sector_wr_en, id_mode, lock_arm_lo, lock_arm_hi, stray_wr};
  endfunction

  // Drive one write; return after the edge that registers its effect
  task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic hexp, input logic [7:0] dexp,
                    input string tag);
    rd_addr = a;
    #1;
    chk(tag, {23'd0, id_rd_hit, id_rd_data}, {23'd0, hexp, dexp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset flags", {27'd0, flags()}, 32'd0);
    chk("R11 wr_ready", {31'd0, wr_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R3 R4 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      do_wr(VA[i], VD[i]);
      chk($sformatf("table step %0d (R1/R3/R4/R7/R8/R9/R10)", i),
          {27'd0, flags()}, {27'd0, VE[i]});
    end

    // R2: writes during open sector write are byte loads
    do_wr(19'h01234, 8'h12);
    chk("R2 load no stray", {27'd0, flags()}, {27'd0, 5'b10000});
    do_wr(19'h05555, 8'hAA);
    do_wr(19'h02AAA, 8'h55);
    do_wr(19'h05555, 8'h90);
    chk("R2 no id while loading", {27'd0, flags()}, {27'd0, 5'b10000});
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
    chk("R2 closed by prog_done", {31'd0, sector_wr_en}, 32'd0);
    do_wr(19'h01234, 8'h12);
    chk("R2 decoding resumes", {27'd0, flags()}, {27'd0, 5'b00001});

    // R5: no hit outside identification mode
    rd(19'h00000, 1'b0, 8'h00, "R5 no id read when off");

    // Enter identification mode
    do_wr(19'h05555, 8'hAA);
    do_wr(19'h02AAA, 8'h55);
    do_wr(19'h05555, 8'h90);
    chk("R3 id on", {31'd0, id_mode}, 32'd1);
    rd(19'h00000, 1'b1, 8'h1F, "R5 maker code");
    rd(19'h00001, 1'b1, 8'hC4, "R5 device code");
    lock_status = 2'b00;
    rd(19'h00002, 1'b1, 8'hFE, "R6 lower unlocked");
    rd(19'h7FFF2, 1'b1, 8'hFE, "R6 upper unlocked");
    lock_status = 2'b01;
    rd(19'h00002, 1'b1, 8'hFF, "R6 lower locked");
    rd(19'h7FFF2, 1'b1, 8'hFE, "R6 upper unaffected");
    lock_status = 2'b10;
    rd(19'h7FFF2, 1'b1, 8'hFF, "R6 upper locked");
    rd(19'h00003, 1'b0, 8'h00, "R6 other address");

    // R9: break in lockout path with a fresh start write
    do_wr(19'h05555, 8'hAA);
    do_wr(19'h02AAA, 8'h55);
    do_wr(19'h05555, 8'h80);
    do_wr(19'h05555, 8'hAA);
    do_wr(19'h05555, 8'hAA);
    chk("R9 restart not stray", {31'd0, stray_wr}, 32'd0);
    do_wr(19'h02AAA, 8'h55);
    do_wr(19'h05555, 8'hF0);
    chk("R9 R4 exit after restart", {31'd0, id_mode}, 32'd0);

    // R7: wrong seventh write arms nothing
    do_wr(19'h05555, 8'hAA);
    do_wr(19'h02AAA, 8'h55);
    do_wr(19'h05555, 8'h80);
    do_wr(19'h05555, 8'hAA);
    do_wr(19'h02AAA, 8'h55);
    do_wr(19'h05555, 8'h40);
    do_wr(19'h00000, 8'hFF);
    chk("R7 wrong seventh", {27'd0, flags()}, {27'd0, 5'b00001});

    // R11: reset clears identification mode
    do_wr(19'h05555, 8'hAA);
    do_wr(19'h02AAA, 8'h55);
    do_wr(19'h05555, 8'h90);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears id", {27'd0, flags()}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_wr(19'h02AAA, 8'h55);
    do_wr(19'h05555, 8'h90);
    chk("R11 matcher idle after reset", {27'd0, flags()}, {27'd0, 5'b00001});

    finish_run();
  end
endmodule